// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs external bus cycles for a 16-bit processor core on a bus where the low sixteen address lines also carry data and the top four address lines are shared with status. The core hands over one transfer at a time: a 20-bit address, memory or I/O space, read or write, and byte or word width. The controller then walks the bus through its T-states. T1 puts out the address and pulses the address-latch strobe. T2 asserts the read or write strobe and turns the lines around for reads. T3 samples READY. Wait states follow for as long as READY stays low, and T4 releases the strobe. When the transfer is complete the controller returns a one-cycle response carrying the read data.

Bank selection uses address bit 0 for the even (low) byte bank and an active-low high-byte enable for the odd (high) byte bank. A word at an odd address becomes two byte cycles. The first cycle goes to the odd byte on the high lane. The second goes to the next, even, address on the low lane, and the two bytes are merged into the returned word. Another bus master can request the bus with HOLD. The controller grants it with HLDA once the transfer in progress has fully finished, and it floats its drivers while the grant lasts.

The core side is a valid/ready request channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and HOLD is low, so the core must keep the request fields stable until that edge. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the core must accept.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle, not granting the bus and HOLD is low; a request is taken on an edge with `req_valid` and `req_ready` both high, and the first bus cycle's T1 starts on that edge.
- R2: In T1, `ale` is high for exactly one cycle, `ad_out` carries address bits 15..0 with `ad_oe` high, and `a_hi` carries address bits 19..16; `ale` is low in every other state.
- R3: `m_io` is 1 for memory cycles and 0 for I/O cycles; an I/O cycle uses only a 16-bit port address, so `a_hi` is 0 in its T1 and the address+1 of a split I/O word wraps within 16 bits.
- R4: A byte at an even address runs one cycle with address bit 0 = 0 and `bhe_n` = 1 on data bits 7..0; a byte at an odd address runs one cycle with address bit 0 = 1 and `bhe_n` = 0 on bits 15..8; a word at an even address runs one cycle with `bhe_n` = 0 on all 16 bits.
- R5: A word at an odd address runs two cycles: first at the odd address with `bhe_n` = 0 moving the word's low byte on bits 15..8, then at address+1 (bit 0 = 0) with `bhe_n` = 1 moving the high byte on bits 7..0.
- R6: For writes the controller drives the data from T2 through T4; a cycle that moves a single byte places that byte on both lanes.
- R7: For reads `ad_oe` is low from T2 to the end of the cycle; the data is captured at the edge that ends the T3 or wait state in which READY is high; a byte read returns the byte in bits 7..0 with bits 15..8 zero.
- R8: `rd_n` (reads) or `wr_n` (writes) is low, and `den_n` is low, from T2 through the last T3/wait state, and never both strobes at once; `dt_r` is 1 during a write cycle and 0 during a read cycle.
- R9: Each cycle with READY low at T3 or in a wait state adds one wait state, so a single cycle lasts 4 + W clocks with W the number of low samples.
- R10: `rsp_valid` is a one-cycle pulse in the cycle after the final T4, with `rsp_rdata` holding the read data; a single-cycle transfer gives the pulse 5 + W cycles after acceptance, a split word 9 + W1 + W2.
- R11: With HOLD high in idle, HLDA rises on the next edge, and `ad_oe`, `ale` and the strobes stay released while HLDA is high; HOLD raised during a transfer is granted only after both halves of a split word and its response; HLDA falls on the edge after HOLD falls.
- R12: RESET is synchronous and active high; it aborts any cycle, returns the controller to idle with the strobes high, `ale` low, `ad_oe` low and no response pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 20 | Physical address of the transfer |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word (16 bits), 0 byte |
| req_wdata | input | 16 | Write data; for a byte, bits 7..0 |
| rsp_valid | output | 1 | One-cycle transfer-done pulse |
| rsp_rdata | output | 16 | Read data (byte in bits 7..0) |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_in | input | 16 | Multiplexed data in |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| a_hi | output | 4 | Address bits 19..16 in T1, zero otherwise |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| m_io | output | 1 | 1 memory cycle, 0 I/O cycle |
| dt_r | output | 1 | Buffer direction, 1 transmit |
| den_n | output | 1 | Buffer enable, active low |
| bhe_n | output | 1 | High-byte bank enable, active low |
| ready | input | 1 | Slow-device ready, active high |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant |

## Verification
The bench aims at the odd-address word. It starts one at 0x0FFFF, where address+1 carries into the upper nibble. It starts another in I/O space at 0xFFFFF, where it must wrap to port 0. A controller that swapped lanes, kept `bhe_n` low in the second cycle, or let the carry escape would return a byte-swapped word or latch the wrong address. The bench holds READY low for several samples and raises HOLD in the middle of a split word. A design that missed either would cut the strobe short or grant the bus between the halves. It also pulses reset during a wait state, and a controller that did not abort would leave a strobe low or emit a stray response.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HLD
  } bus_st_e;

  typedef enum logic [1:0] {
    LANE_LO,
    LANE_HI,
    LANE_BOTH
  } lane_e;
endpackage

// File: rtl/mbc_plan.sv
// Works out address, bank enable, lane and write data of the current bus cycle.
module mbc_plan
  import mbc_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int IOW = 16
) (
  input  logic [AW-1:0] base_addr,
  input  logic          is_mem,
  input  logic          is_word,
  input  logic          second,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] cyc_addr,
  output logic          bhe_n,
  output lane_e         lane,
  output logic          split,
  output logic [DW-1:0] drv_data
);
  localparam int BW = DW / 2;

  logic [AW-1:0] raw;
  logic [BW-1:0] one_byte;

  assign raw   = second ? (base_addr + AW'(1)) : base_addr;
  assign split = is_word && base_addr[0];

  generate
    if (IOW < AW) begin : g_iomask
      always_comb cyc_addr = is_mem ? raw : {{(AW-IOW){1'b0}}, raw[IOW-1:0]};
    end else begin : g_nomask
      always_comb cyc_addr = raw;
    end
  endgenerate

  always_comb begin
    if (is_word && !base_addr[0]) lane = LANE_BOTH;
    else if (second)              lane = LANE_LO;
    else if (base_addr[0])        lane = LANE_HI;
    else                          lane = LANE_LO;
  end

  assign bhe_n    = (lane == LANE_LO);
  assign one_byte = second ? wdata[DW-1:BW] : wdata[BW-1:0];
  assign drv_data = (lane == LANE_BOTH) ? wdata : {one_byte, one_byte};
endmodule

// File: rtl/mbc_fsm.sv
// T-state sequencer: T1, T2, T3, wait states, T4, plus bus grant.
module mbc_fsm
  import mbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_fire,
  input  logic    split,
  input  logic    is_write,
  input  logic    hold,
  input  logic    ready,
  output bus_st_e state,
  output logic    second,
  output logic    cap,
  output logic    done
);
  bus_st_e nxt;
  logic    last_half;

  assign last_half = !split || second;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (hold)          nxt = ST_HLD;
        else if (req_fire) nxt = ST_T1;
      end
      ST_T1:        nxt = ST_T2;
      ST_T2:        nxt = ST_T3;
      ST_T3, ST_TW: nxt = ready ? ST_T4 : ST_TW;
      ST_T4:        nxt = last_half ? ST_IDLE : ST_T1;
      ST_HLD:       if (!hold) nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      second <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_T4) && last_half;
      if (req_fire)                           second <= 1'b0;
      else if (state == ST_T4 && !last_half)  second <= 1'b1;
    end
  end

  assign cap = (state == ST_T3 || state == ST_TW) && ready && !is_write;
endmodule

// File: rtl/mbc_merge.sv
// Captures read bytes from the proper lane into the returned word.
module mbc_merge
  import mbc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          cap,
  input  lane_e         lane,
  input  logic          second,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] rdata
);
  localparam int BW = DW / 2;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rdata <= '0;
    end else if (cap) begin
      unique case (lane)
        LANE_BOTH: rdata <= bus_in;
        LANE_HI:   rdata[BW-1:0] <= bus_in[DW-1:BW];
        default: begin
          if (second) rdata[DW-1:BW] <= bus_in[BW-1:0];
          else        rdata[BW-1:0]  <= bus_in[BW-1:0];
        end
      endcase
    end
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int IO_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_mem,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     m_io,
  output logic                     dt_r,
  output logic                     den_n,
  output logic                     bhe_n,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda
);
  localparam int HI_W = ADDR_W - DATA_W;

  bus_st_e           state;
  logic              fire, second, cap, split, busy, strobe_ph, plan_bhe_n;
  lane_e             lane;
  logic [ADDR_W-1:0] r_addr, cyc_addr;
  logic [DATA_W-1:0] r_wdata, drv_data;
  logic              r_mem, r_write, r_word;

  assign req_ready = (state == ST_IDLE) && !hold;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_addr  <= '0;
      r_wdata <= '0;
      r_mem   <= 1'b0;
      r_write <= 1'b0;
      r_word  <= 1'b0;
    end else if (fire) begin
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
      r_mem   <= req_mem;
      r_write <= req_write;
      r_word  <= req_word;
    end
  end

  mbc_plan #(.AW(ADDR_W), .DW(DATA_W), .IOW(IO_W)) u_plan (
    .base_addr (r_addr),
    .is_mem    (r_mem),
    .is_word   (r_word),
    .second    (second),
    .wdata     (r_wdata),
    .cyc_addr  (cyc_addr),
    .bhe_n     (plan_bhe_n),
    .lane      (lane),
    .split     (split),
    .drv_data  (drv_data)
  );

  mbc_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req_fire (fire),
    .split    (split),
    .is_write (r_write),
    .hold     (hold),
    .ready    (ready),
    .state    (state),
    .second   (second),
    .cap      (cap),
    .done     (rsp_valid)
  );

  mbc_merge #(.DW(DATA_W)) u_merge (
    .clk    (clk),
    .rst    (rst),
    .clr    (fire),
    .cap    (cap),
    .lane   (lane),
    .second (second),
    .bus_in (ad_in),
    .rdata  (rsp_rdata)
  );

  assign busy      = (state == ST_T1) || (state == ST_T2) || (state == ST_T3) ||
                     (state == ST_TW) || (state == ST_T4);
  assign strobe_ph = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);

  assign ale    = (state == ST_T1);
  assign ad_oe  = ale || (r_write && (strobe_ph || state == ST_T4));
  assign ad_out = ale ? cyc_addr[DATA_W-1:0] : drv_data;
  assign a_hi   = ale ? cyc_addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign rd_n   = !(strobe_ph && !r_write);
  assign wr_n   = !(strobe_ph && r_write);
  assign den_n  = !strobe_ph;
  assign m_io   = busy && r_mem;
  assign dt_r   = busy && r_write;
  assign bhe_n  = busy ? plan_bhe_n : 1'b1;
  assign hlda   = (state == ST_HLD);
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            den_n,
  input logic            ad_oe,
  input logic            hlda,
  input logic            hold,
  input logic            ready,
  input logic            rsp_valid,
  input logic            req_ready,
  input logic            m_io,
  input logic [HI_W-1:0] a_hi
);
  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
  p_ale_addr_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (ad_oe && rd_n && wr_n && den_n));
  p_io_port_r3: assert property (@(posedge clk) disable iff (rst)
    (ale && !m_io) |-> (a_hi == '0));
  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
  p_den_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> (!rd_n || !wr_n));
  p_wait_rd_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n) && !ready) |=> !rd_n);
  p_wait_wr_r9: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(!wr_n) && !ready) |=> !wr_n);
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
  p_grant_float_r11: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && rd_n && wr_n && !ale && !req_ready));
  p_grant_cause_r11: assert property (@(posedge clk) disable iff (rst) hlda |-> $past(hold));
  p_reset_idle_r12: assert property (@(posedge clk)
    rst |=> (rd_n && wr_n && !ale && !hlda && !rsp_valid));
endmodule

bind mux_bus_ctrl mbc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .den_n     (den_n),
  .ad_oe     (ad_oe),
  .hlda      (hlda),
  .hold      (hold),
  .ready     (ready),
  .rsp_valid (rsp_valid),
  .req_ready (req_ready),
  .m_io      (m_io),
  .a_hi      (a_hi)
);

// File: tb/sim_mux_bus_ctrl.sv
module sim_mux_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst;
  logic        req_valid, req_ready, req_mem, req_write, req_word;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata, ad_out, ad_in;
  logic        rsp_valid, ad_oe, ale, rd_n, wr_n, m_io, dt_r, den_n, bhe_n;
  logic        rdy_in, hold, hlda;
  logic [3:0]  a_hi;

  int checks = 0;
  int errs   = 0;
  int wd     = 0;
  int waits_cfg = 0;
  int s_cnt = 0;

  // bench-side latch and per-request log
  logic [19:0] lat = '0;
  logic [19:0] log_addr [2];
  logic        log_bhe  [2];
  logic        log_mio  [2];
  logic        log_dtr  [2];
  logic [15:0] wlog     [2];
  int          n_ale = 0;
  int          strobe_cycles = 0;
  bit          bad_oe = 0;
  bit          grant_busy = 0;

  mux_bus_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mem(req_mem), .req_write(req_write), .req_word(req_word),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .m_io(m_io), .dt_r(dt_r), .den_n(den_n), .bhe_n(bhe_n),
    .ready(rdy_in), .hold(hold), .hlda(hlda)
  );

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h5A;
  endfunction

  assign ad_in = {mbyte(lat | 20'h1), mbyte(lat & ~20'h1)};

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd == 20000) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // slow-device model and bus monitor
  always @(negedge clk) begin
    if (!rd_n || !wr_n) s_cnt = s_cnt + 1;
    else                s_cnt = 0;
    rdy_in = (s_cnt == 0) || (s_cnt >= 2 + waits_cfg);
    if (ale) begin
      lat = {a_hi, ad_out};
      if (n_ale < 2) begin
        log_addr[n_ale] = lat;
        log_bhe[n_ale]  = bhe_n;
        log_mio[n_ale]  = m_io;
        log_dtr[n_ale]  = dt_r;
      end
      n_ale++;
    end
    if (!wr_n && n_ale >= 1 && n_ale <= 2) wlog[n_ale-1] = ad_out;
    if (!rd_n || !wr_n) strobe_cycles++;
    if (!rd_n && ad_oe) bad_oe = 1;
    if (!wr_n && !ad_oe) bad_oe = 1;
    if (hlda && (ale || !rd_n || !wr_n || ad_oe)) grant_busy = 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic drive_req(input logic [19:0] a, input bit mem, input bit wr,
                           input bit word, input logic [15:0] wdat);
    n_ale = 0; strobe_cycles = 0; bad_oe = 0;
    wlog[0] = '0; wlog[1] = '0;
    req_addr = a; req_mem = mem; req_write = wr; req_word = word; req_wdata = wdat;
    req_valid = 1'b1;
  endtask

  // returns at the sample of T1 of the first cycle
  task automatic wait_accept();
    bit took;
    took = 0;
    for (int i = 0; i < 100 && !took; i++) begin
      #1;
      took = req_ready;
      tick();
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [15:0] rd, output int ncyc);
    ncyc = 1;
    rd = '0;
    for (int i = 0; i < 100; i++) begin
      tick();
      ncyc++;
      if (rsp_valid) begin
        rd = rsp_rdata;
        break;
      end
    end
  endtask

  task automatic issue(input logic [19:0] a, input bit mem, input bit wr, input bit word,
                       input logic [15:0] wdat, output logic [15:0] rd, output int ncyc);
    drive_req(a, mem, wr, word, wdat);
    wait_accept();
    wait_rsp(rd, ncyc);
  endtask

  task automatic t_reset_state();
    chk("R12 req_ready", req_ready, 1);
    chk("R12 strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R12 ale/oe/hlda/rsp", {ale, ad_oe, hlda, rsp_valid}, 4'b0000);
  endtask

  task automatic t_word_even_read();
    logic [15:0] rd; int n;
    waits_cfg = 0;
    issue(20'h3A4C6, 1, 0, 1, 16'h0, rd, n);
    chk("R2 latched address", log_addr[0], 20'h3A4C6);
    chk("R4 even word bhe_n", log_bhe[0], 0);
    chk("R3 memory m_io", log_mio[0], 1);
    chk("R8 read dt_r", log_dtr[0], 0);
    chk("R7 read turnaround", bad_oe, 0);
    chk("R8 strobe length", strobe_cycles, 2);
    chk("R10 latency", n, 5);
    chk("R10 read data", rd, {mbyte(20'h3A4C7), mbyte(20'h3A4C6)});
    chk("R4 cycle count", n_ale, 1);
  endtask

  task automatic t_byte_reads();
    logic [15:0] rd; int n;
    issue(20'h12340, 1, 0, 0, 16'h0, rd, n);
    chk("R4 even byte bhe_n", log_bhe[0], 1);
    chk("R7 even byte data", rd, {8'h00, mbyte(20'h12340)});
    issue(20'h12341, 1, 0, 0, 16'h0, rd, n);
    chk("R4 odd byte address", log_addr[0], 20'h12341);
    chk("R4 odd byte bhe_n", log_bhe[0], 0);
    chk("R7 odd byte data", rd, {8'h00, mbyte(20'h12341)});
  endtask

  task automatic t_split_read();
    logic [15:0] rd; int n;
    issue(20'h0FFFF, 1, 0, 1, 16'h0, rd, n);
    chk("R5 two cycles", n_ale, 2);
    chk("R5 first address", log_addr[0], 20'h0FFFF);
    chk("R5 first bhe_n", log_bhe[0], 0);
    chk("R5 second address carry", log_addr[1], 20'h10000);
    chk("R5 second bhe_n", log_bhe[1], 1);
    chk("R10 split latency", n, 9);
    chk("R5 merged word", rd, {mbyte(20'h10000), mbyte(20'h0FFFF)});
  endtask

  task automatic t_io_split();
    logic [15:0] rd; int n;
    issue(20'hFFFFF, 0, 0, 1, 16'h0, rd, n);
    chk("R3 io m_io", log_mio[0], 0);
    chk("R3 io first port", log_addr[0], 20'h0FFFF);
    chk("R3 io port wrap", log_addr[1], 20'h00000);
    chk("R3 io word data", rd, {mbyte(20'h00000), mbyte(20'h0FFFF)});
  endtask

  task automatic t_writes();
    logic [15:0] rd; int n;
    issue(20'h00200, 1, 1, 1, 16'hBEEF, rd, n);
    chk("R6 even word write", wlog[0], 16'hBEEF);
    chk("R8 write dt_r", log_dtr[0], 1);
    chk("R6 write drive", bad_oe, 0);
    chk("R10 write latency", n, 5);
    issue(20'h00203, 1, 1, 0, 16'h1177, rd, n);
    chk("R6 odd byte both lanes", wlog[0], 16'h7777);
    chk("R4 odd byte write bhe_n", log_bhe[0], 0);
    issue(20'h00204, 1, 1, 0, 16'h0042, rd, n);
    chk("R6 even byte both lanes", wlog[0], 16'h4242);
    chk("R4 even byte write bhe_n", log_bhe[0], 1);
    issue(20'h00205, 1, 1, 1, 16'hA1B2, rd, n);
    chk("R5 split write low byte", wlog[0], 16'hB2B2);
    chk("R5 split write high byte", wlog[1], 16'hA1A1);
    chk("R5 split write second address", log_addr[1], 20'h00206);
  endtask

  task automatic t_wait_states();
    logic [15:0] rd; int n;
    waits_cfg = 3;
    issue(20'h00400, 1, 0, 1, 16'h0, rd, n);
    chk("R9 stretched strobe", strobe_cycles, 5);
    chk("R9 latency with waits", n, 8);
    chk("R9 data after waits", rd, {mbyte(20'h00401), mbyte(20'h00400)});
    waits_cfg = 0;
  endtask

  task automatic t_hold_idle();
    logic [15:0] rd; int n;
    grant_busy = 0;
    hold = 1'b1;
    drive_req(20'h00800, 1, 0, 1, 16'h0);
    tick();
    chk("R11 hlda rises", hlda, 1);
    chk("R1 no ready in hold", req_ready, 0);
    repeat (3) tick();
    chk("R1 no cycle during grant", n_ale, 0);
    hold = 1'b0;
    tick();
    chk("R11 hlda falls", hlda, 0);
    wait_accept();
    wait_rsp(rd, n);
    chk("R1 request after grant", rd, {mbyte(20'h00801), mbyte(20'h00800)});
    chk("R11 floated while granted", grant_busy, 0);
  endtask

  task automatic t_hold_mid();
    logic [15:0] rd; int n;
    grant_busy = 0;
    drive_req(20'h00101, 1, 0, 1, 16'h0);
    wait_accept();
    hold = 1'b1;
    wait_rsp(rd, n);
    chk("R11 both halves before grant", n_ale, 2);
    chk("R11 no extra delay", n, 9);
    chk("R11 hlda low at response", hlda, 0);
    tick();
    chk("R11 hlda after response", hlda, 1);
    hold = 1'b0;
    tick();
    chk("R11 released", {hlda, req_ready}, 2'b01);
    chk("R11 floated while granted", grant_busy, 0);
    chk("R5 data across hold", rd, {mbyte(20'h00102), mbyte(20'h00101)});
  endtask

  task automatic t_reset_abort();
    logic [15:0] rd; int n;
    bit stray;
    stray = 0;
    waits_cfg = 6;
    drive_req(20'h00500, 1, 0, 1, 16'h0);
    wait_accept();
    tick();
    tick();
    chk("R12 strobe active before reset", rd_n, 0);
    rst = 1'b1;
    tick();
    chk("R12 abort strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R12 abort ale/oe", {ale, ad_oe}, 2'b00);
    repeat (3) begin
      tick();
      if (rsp_valid) stray = 1;
    end
    rst = 1'b0;
    waits_cfg = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (rsp_valid) stray = 1;
    end
    chk("R12 no stray response", stray, 0);
    chk("R12 idle after reset", {req_ready, rd_n}, 2'b11);
    issue(20'h00600, 1, 0, 1, 16'h0, rd, n);
    chk("R12 works after abort", rd, {mbyte(20'h00601), mbyte(20'h00600)});
  endtask

  initial begin
    rst = 1'b1; hold = 1'b0; req_valid = 1'b0; rdy_in = 1'b1;
    req_addr = '0; req_mem = 0; req_write = 0; req_word = 0; req_wdata = '0;
    repeat (5) tick();
    rst = 1'b0;
    tick();
    t_reset_state();
    t_word_even_read();
    t_byte_reads();
    t_split_read();
    t_io_split();
    t_writes();
    t_wait_states();
    t_hold_idle();
    t_hold_mid();
    t_reset_abort();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule